// File: doc/BRIEF.md
# Serial Auto-Baud Synchronizer

This block sits on a serial receive/transmit line pair that runs 8 data bits, 1 stop bit, no parity, least significant bit first, at a rate the block does not know in advance. It waits for the host to send a question mark (0x3F). It times how long that character's start bit stays low, counted in its own clock cycles, and from then on uses the count as the bit period of its own receiver and transmitter.

Once the period is known, the block runs a short text exchange. It sends the greeting `Synchronized` CR LF. The host must echo those fourteen bytes exactly, and the block then answers `OK` CR LF. The host next sends its clock frequency in kHz as decimal digits ending in CR LF. The block accumulates the number, answers `OK` CR LF a second time and raises a flag that stays high until reset. A wrong byte, a bad frame or a malformed number at any point of the exchange sends the block back to waiting for a new question mark.

Top module: `abs_sync_top`

## Requirements
- R1: After reset the transmit line is high (idle), the synchronized flag is 0, and the divisor and frequency outputs are 0.
- R2: On a 0x3F character, the divisor output equals the number of clock cycles the start bit held the receive line low. The greeting is sent at that divisor.
- R3: A low pulse on the receive line shorter than MIN_DIV cycles is discarded. No byte is sent, the flag stays 0, the divisor stays unchanged, and a later valid 0x3F is still measured.
- R4: After measurement the block sends the 14 bytes 53 79 6E 63 68 72 6F 6E 69 7A 65 64 0D 0A. Each byte is framed as a start bit of 0, then 8 data bits LSB first, then a stop bit of 1, and each bit lasts divisor cycles.
- R5: When the host returns exactly those 14 bytes, the block sends 4F 4B 0D 0A.
- R6: The first echo byte that differs from the greeting returns the block to hunting. Nothing further is sent, and the next 0x3F is measured afresh, possibly at a new period.
- R7: Digit bytes 0x30-0x39 update a 32-bit value as value*10+digit, modulo 2^32. The sequence CR (0x0D) then LF (0x0A) ends the line. The block then sends 4F 4B 0D 0A, sets the frequency output to the value and raises the synchronized flag.
- R8: Any of the following in the frequency line returns the block to hunting, with no reply: a non-digit byte before CR, a CR with no digits before it, or a byte other than LF after the CR.
- R9: A byte whose stop bit is sampled low during the echo or the frequency line returns the block to hunting, with no reply.
- R10: Once the flag is high, it stays high until reset. Further received bytes, including 0x3F, cause no transmission and leave the frequency and divisor outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial receive line from the host, idle high |
| txd_o | output | 1 | Serial transmit line to the host, idle high |
| synced_o | output | 1 | High once the whole exchange has succeeded |
| divisor_o | output | DIV_W | Measured bit period in clock cycles |
| freq_khz_o | output | FREQ_W | Decimal frequency value received from the host |

## Verification
The full exchange is swept over bit periods of 8, 12, 17 and 32 cycles. The frequency values include a one-digit number and the 32-bit maximum. The sweep separates a correct divisor from one that is off by a cycle, and correct decimal accumulation from wrapped or truncated values. Failure cases are placed at specific points: a short glitch before the sync character, a wrong final echo byte, a non-digit, an empty line, a missing LF, and a low stop bit in both the echo and the digits. In each case the transmit line must stay quiet, and a later resync at a different period must succeed, which shows the block really returned to hunting. Bytes sent after success must change nothing.

// File: rtl/abs_pkg.sv
// Shared types and message tables for the auto-baud synchronizer.
// Assumes 8-bit ASCII bytes; message indices never exceed the message length.
package abs_pkg;

    localparam int SYNC_LEN = 14;
    localparam int OK_LEN   = 4;
    localparam logic [7:0] CH_QMARK = 8'h3F;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_NINE  = 8'h39;

    typedef enum logic [2:0] {
        HS_HUNT,
        HS_TX_GREET,
        HS_RX_ECHO,
        HS_TX_ACK1,
        HS_RX_DIGITS,
        HS_RX_LF,
        HS_TX_ACK2,
        HS_DONE
    } hs_state_t;

    typedef enum logic [2:0] {
        MT_IDLE,
        MT_LOW,
        MT_SKIP_HI,
        MT_SKIP_LO,
        MT_ABORT
    } meter_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Byte idx of the greeting (ack_sel=0) or of the acknowledge (ack_sel=1).
    function automatic logic [7:0] msg_char(input logic ack_sel, input logic [3:0] idx);
        logic [7:0] c;
        if (ack_sel) begin
            case (idx)
                4'd0:    c = 8'h4F;
                4'd1:    c = 8'h4B;
                4'd2:    c = CH_CR;
                default: c = CH_LF;
            endcase
        end else begin
            case (idx)
                4'd0:    c = 8'h53;
                4'd1:    c = 8'h79;
                4'd2:    c = 8'h6E;
                4'd3:    c = 8'h63;
                4'd4:    c = 8'h68;
                4'd5:    c = 8'h72;
                4'd6:    c = 8'h6F;
                4'd7:    c = 8'h6E;
                4'd8:    c = 8'h69;
                4'd9:    c = 8'h7A;
                4'd10:   c = 8'h65;
                4'd11:   c = 8'h64;
                4'd12:   c = CH_CR;
                default: c = CH_LF;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/abs_bit_meter.sv
// Measures the start-bit length of a 0x3F character on the synchronized
// receive line, then skips the rest of that frame (high run, low run, stop
// rise) before reporting. Assumes the line is idle high when enabled.
module abs_bit_meter
    import abs_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_s,
    output logic             done,
    output logic [DIV_W-1:0] period
);
    localparam logic [DIV_W-1:0] MIN_C   = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] CNT_MAX = '1;

    meter_state_t     st;
    logic             prev;
    logic [DIV_W-1:0] cnt;

    // Edge timing state machine: count low cycles, then walk to the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= MT_IDLE;
            prev   <= 1'b1;
            cnt    <= '0;
            done   <= 1'b0;
            period <= '0;
        end else begin
            prev <= rx_s;
            done <= 1'b0;
            if (!en) begin
                st <= MT_IDLE;
            end else begin
                case (st)
                    MT_IDLE: begin
                        if (prev && !rx_s) begin
                            cnt <= DIV_W'(1);
                            st  <= MT_LOW;
                        end
                    end
                    MT_LOW: begin
                        if (!rx_s) begin
                            if (cnt == CNT_MAX) st <= MT_ABORT;
                            else                cnt <= cnt + 1'b1;
                        end else if (cnt >= MIN_C) begin
                            st <= MT_SKIP_HI;
                        end else begin
                            st <= MT_IDLE;
                        end
                    end
                    MT_SKIP_HI: if (!rx_s) st <= MT_SKIP_LO;
                    MT_SKIP_LO: begin
                        if (rx_s) begin
                            done   <= 1'b1;
                            period <= cnt;
                            st     <= MT_IDLE;
                        end
                    end
                    MT_ABORT: if (rx_s) st <= MT_IDLE;
                    default:  st <= MT_IDLE;
                endcase
            end
        end
    end

    // R2
    meas_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> period >= MIN_C);

    // R3
    glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == MT_LOW && rx_s && cnt < MIN_C) |=> !done);

endmodule

// File: rtl/abs_uart_rx.sv
// Byte receiver with a runtime bit period. Samples at mid-bit, reports one
// pulse per frame with a flag for a low stop bit. Held idle while disabled.
module abs_uart_rx
    import abs_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_s,
    input  logic [DIV_W-1:0] div,
    output logic             valid,
    output logic [7:0]       data,
    output logic             ferr
);
    rx_state_t        st;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;

    // Half and full bit boundaries derived from the runtime divisor.
    always_comb begin
        half = div >> 1;
        last = div - DIV_W'(1);
    end

    // Frame reception: start check, eight data samples, stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            valid <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            cnt <= DIV_W'(1);
                            st  <= RX_START;
                        end
                    end
                    RX_START: begin
                        if (cnt >= half) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == last) begin
                            cnt  <= '0;
                            sh   <= {rx_s, sh[7:1]};
                            bitn <= bitn + 1'b1;
                            if (bitn == 3'd7) st <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == last) begin
                            valid <= 1'b1;
                            data  <= sh;
                            ferr  <= !rx_s;
                            st    <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/abs_uart_tx.sv
// Byte transmitter with a runtime bit period: start 0, 8 data LSB first,
// stop 1. Accepts a byte on go while ready; line idles high.
module abs_uart_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             go,
    input  logic [7:0]       byte_in,
    output logic             ready,
    output logic             txd_o
);
    logic             busy;
    logic [9:0]       sh;
    logic [DIV_W-1:0] cnt;
    logic [3:0]       nbits;

    // Load a frame on go, then shift one bit every div cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sh    <= '1;
            cnt   <= '0;
            nbits <= '0;
        end else if (!busy) begin
            if (go) begin
                sh    <= {1'b1, byte_in, 1'b0};
                busy  <= 1'b1;
                cnt   <= '0;
                nbits <= '0;
            end
        end else if (cnt == div - DIV_W'(1)) begin
            cnt <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (nbits == 4'd9) busy  <= 1'b0;
            else               nbits <= nbits + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = !busy;
    assign txd_o = !busy | sh[0];

    // R4
    tx_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    // R4
    tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |-> $stable(txd_o));

endmodule

// File: rtl/abs_hs_ctrl.sv
// Handshake sequencer: greeting, echo compare, first acknowledge, decimal
// frequency line, second acknowledge. Any fault returns to hunting.
// Assumes the host waits for each reply before sending the next line.
module abs_hs_ctrl
    import abs_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_done,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_ferr,
    input  logic              tx_ready,
    output logic              meter_en,
    output logic              rx_en,
    output logic              tx_go,
    output logic [7:0]        tx_byte,
    output logic              synced,
    output logic [FREQ_W-1:0] freq
);
    hs_state_t         st;
    logic [3:0]        idx;
    logic [FREQ_W-1:0] acc;
    logic              have_digit;
    logic              is_digit;
    logic              can_send;
    logic [FREQ_W-1:0] digit_val;

    // Decode helpers for the received byte and the transmit slot.
    always_comb begin
        is_digit  = (rx_data >= CH_ZERO) && (rx_data <= CH_NINE);
        can_send  = tx_ready && !tx_go;
        digit_val = FREQ_W'(rx_data - CH_ZERO);
        meter_en  = (st == HS_HUNT);
        rx_en     = (st != HS_HUNT) && (st != HS_DONE);
    end

    // Sequencer state, message index and decimal accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= HS_HUNT;
            idx        <= '0;
            acc        <= '0;
            have_digit <= 1'b0;
            tx_go      <= 1'b0;
            tx_byte    <= '0;
            synced     <= 1'b0;
            freq       <= '0;
        end else begin
            tx_go <= 1'b0;
            case (st)
                HS_HUNT: begin
                    idx <= '0;
                    if (meas_done) st <= HS_TX_GREET;
                end
                HS_TX_GREET: begin
                    if (can_send) begin
                        tx_go   <= 1'b1;
                        tx_byte <= msg_char(1'b0, idx);
                        if (idx == 4'(SYNC_LEN - 1)) begin
                            idx <= '0;
                            st  <= HS_RX_ECHO;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                HS_RX_ECHO: begin
                    if (rx_valid) begin
                        if (rx_ferr || rx_data != msg_char(1'b0, idx)) begin
                            st <= HS_HUNT;
                        end else if (idx == 4'(SYNC_LEN - 1)) begin
                            idx <= '0;
                            st  <= HS_TX_ACK1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                HS_TX_ACK1: begin
                    if (can_send) begin
                        tx_go   <= 1'b1;
                        tx_byte <= msg_char(1'b1, idx);
                        if (idx == 4'(OK_LEN - 1)) begin
                            idx        <= '0;
                            acc        <= '0;
                            have_digit <= 1'b0;
                            st         <= HS_RX_DIGITS;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                HS_RX_DIGITS: begin
                    if (rx_valid) begin
                        if (rx_ferr) begin
                            st <= HS_HUNT;
                        end else if (is_digit) begin
                            acc        <= acc * FREQ_W'(10) + digit_val;
                            have_digit <= 1'b1;
                        end else if (rx_data == CH_CR && have_digit) begin
                            st <= HS_RX_LF;
                        end else begin
                            st <= HS_HUNT;
                        end
                    end
                end
                HS_RX_LF: begin
                    if (rx_valid) begin
                        if (!rx_ferr && rx_data == CH_LF) begin
                            freq <= acc;
                            st   <= HS_TX_ACK2;
                        end else begin
                            st <= HS_HUNT;
                        end
                    end
                end
                HS_TX_ACK2: begin
                    if (can_send) begin
                        tx_go   <= 1'b1;
                        tx_byte <= msg_char(1'b1, idx);
                        if (idx == 4'(OK_LEN - 1)) begin
                            idx    <= '0;
                            synced <= 1'b1;
                            st     <= HS_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                HS_DONE: st <= HS_DONE;
                default: st <= HS_HUNT;
            endcase
        end
    end

    // R10
    synced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> (synced && $stable(freq)));

endmodule

// File: rtl/abs_sync_top.sv
// Auto-baud synchronizer top: input synchronizer, start-bit meter, byte
// receiver, byte transmitter and handshake sequencer. The measured period
// drives both serial units directly.
module abs_sync_top
    import abs_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 4,
    parameter int FREQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              synced_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic [FREQ_W-1:0] freq_khz_o
);
    logic             rx_meta;
    logic             rx_s;
    logic             meter_en;
    logic             meas_done;
    logic [DIV_W-1:0] period;
    logic             rx_en;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             rx_ferr;
    logic             tx_go;
    logic [7:0]       tx_byte;
    logic             tx_ready;

    // Two-stage synchronizer for the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd_i;
            rx_s    <= rx_meta;
        end
    end

    abs_bit_meter #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_meter (
        .clk(clk), .rst_n(rst_n), .en(meter_en), .rx_s(rx_s),
        .done(meas_done), .period(period)
    );

    abs_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .rx_s(rx_s), .div(period),
        .valid(rx_valid), .data(rx_data), .ferr(rx_ferr)
    );

    abs_uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(period), .go(tx_go),
        .byte_in(tx_byte), .ready(tx_ready), .txd_o(txd_o)
    );

    abs_hs_ctrl #(.FREQ_W(FREQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .meas_done(meas_done),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .tx_ready(tx_ready), .meter_en(meter_en), .rx_en(rx_en),
        .tx_go(tx_go), .tx_byte(tx_byte), .synced(synced_o), .freq(freq_khz_o)
    );

    assign divisor_o = period;

    // R2
    synced_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |-> divisor_o >= DIV_W'(MIN_DIV));

endmodule

// File: tb/sim_abs_sync_top.sv
module sim_abs_sync_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic        synced;
    logic [15:0] divisor;
    logic [31:0] freq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    abs_sync_top u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd),
        .synced_o(synced), .divisor_o(divisor), .freq_khz_o(freq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        rxd   = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int bl, input bit bad_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bl) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bl) @(negedge clk);
        end
        rxd = bad_stop ? 1'b0 : 1'b1;
        repeat (bl) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic send_str(input string s, input int bl);
        for (int i = 0; i < s.len(); i++) send_byte(s[i], bl, 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] b, input int bl);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (bl / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bl) @(negedge clk);
            b[i] = txd;
        end
        repeat (bl) @(negedge clk);
    endtask

    task automatic expect_str(input string exp, input int bl, input string req);
        logic [7:0] b;
        int bad = 0;
        int first = -1;
        logic [7:0] got_b = 8'h00;
        for (int i = 0; i < exp.len(); i++) begin
            recv_byte(b, bl);
            if (b != exp[i]) begin
                bad++;
                if (first < 0) begin
                    first = i;
                    got_b = b;
                end
            end
        end
        if (first < 0) check(1'b1, req, "reply bytes", 0, 0);
        else check(1'b0, req, $sformatf("reply byte %0d", first), got_b, exp[first]);
    endtask

    task automatic quiet(input int cycles, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, req, "transmit line low cycles", lows, 0);
    endtask

    function automatic string greet();
        return $sformatf("Synchronized%c%c", 8'd13, 8'd10);
    endfunction

    function automatic string ack();
        return $sformatf("OK%c%c", 8'd13, 8'd10);
    endfunction

    task automatic sync_phase(input int bl);
        fork
            send_byte(8'h3F, bl, 1'b0);
            expect_str(greet(), bl, "R4");
        join
        check(divisor == 16'(bl), "R2", "divisor", divisor, bl);
    endtask

    task automatic echo_phase(input int bl);
        fork
            send_str(greet(), bl);
            expect_str(ack(), bl, "R5");
        join
    endtask

    task automatic freq_phase(input int bl, input logic [31:0] f);
        fork
            send_str($sformatf("%0d%c%c", f, 8'd13, 8'd10), bl);
            expect_str(ack(), bl, "R7");
        join
        repeat (2 * bl) @(negedge clk);
        check(synced == 1'b1, "R7", "synced flag", synced, 1);
        check(freq == f, "R7", "frequency value", freq, f);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int bls[4];
        logic [31:0] fqs[4];
        bls = '{8, 12, 17, 32};
        fqs = '{32'd10000, 32'd7, 32'd123456, 32'hFFFF_FFFF};

        // R1: reset state
        reset_dut();
        check(txd == 1'b1, "R1", "idle transmit line", txd, 1);
        check(synced == 1'b0, "R1", "synced flag", synced, 0);
        check(divisor == 16'd0, "R1", "divisor", divisor, 0);
        check(freq == 32'd0, "R1", "frequency", freq, 0);

        // R2 R4 R5 R7: full exchange swept over periods and values
        for (int k = 0; k < 4; k++) begin
            reset_dut();
            sync_phase(bls[k]);
            echo_phase(bls[k]);
            freq_phase(bls[k], fqs[k]);
            if (k == 0) begin
                // R10: later bytes change nothing
                fork
                    begin
                        send_str($sformatf("99%c%c", 8'd13, 8'd10), bls[k]);
                        send_byte(8'h3F, bls[k], 1'b0);
                    end
                    quiet(60 * bls[k], "R10");
                join
                repeat (4 * bls[k]) @(negedge clk);
                check(synced == 1'b1, "R10", "synced flag", synced, 1);
                check(freq == fqs[k], "R10", "frequency", freq, fqs[k]);
                check(divisor == 16'(bls[k]), "R10", "divisor", divisor, bls[k]);
            end
        end

        // R3: short glitch discarded, later sync still works
        reset_dut();
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        quiet(300, "R3");
        check(synced == 1'b0, "R3", "synced flag", synced, 0);
        check(divisor == 16'd0, "R3", "divisor", divisor, 0);
        sync_phase(10);

        // R6: wrong final echo byte, then resync at a new period
        reset_dut();
        sync_phase(16);
        send_str($sformatf("Synchronized%c", 8'd13), 16);
        send_byte(8'h51, 16, 1'b0);
        quiet(30 * 16, "R6");
        check(synced == 1'b0, "R6", "synced flag", synced, 0);
        sync_phase(9);
        check(divisor == 16'd9, "R6", "new divisor", divisor, 9);
        echo_phase(9);
        freq_phase(9, 32'd500);

        // R8: non-digit, empty line, missing LF, then success
        reset_dut();
        sync_phase(12);
        echo_phase(12);
        send_str("12a", 12);
        quiet(30 * 12, "R8");
        sync_phase(12);
        echo_phase(12);
        send_byte(8'h0D, 12, 1'b0);
        quiet(30 * 12, "R8");
        sync_phase(12);
        echo_phase(12);
        send_str($sformatf("5%c", 8'd13), 12);
        send_byte(8'h78, 12, 1'b0);
        quiet(30 * 12, "R8");
        check(synced == 1'b0, "R8", "synced flag", synced, 0);
        sync_phase(12);
        echo_phase(12);
        freq_phase(12, 32'd42);

        // R9: low stop bit in echo and in digits
        reset_dut();
        sync_phase(11);
        send_byte(8'h53, 11, 1'b1);
        quiet(30 * 11, "R9");
        sync_phase(11);
        echo_phase(11);
        send_byte(8'h34, 11, 1'b1);
        quiet(30 * 11, "R9");
        check(synced == 1'b0, "R9", "synced flag", synced, 0);
        sync_phase(11);
        echo_phase(11);
        freq_phase(11, 32'd4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule